// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block turns a set of external interrupt pins (24 by default) into interrupt delivery messages. Each pin owns a 64-bit redirection entry that says which vector to deliver, how to deliver it, where to send it, and whether the pin is level or edge sensitive. Software never addresses an entry directly. It writes an 8-bit selector at offset 0x00 and then reads or writes the selected 32-bit word through a data window at offset 0x10. Each entry is split into a low word and a high word.

The block keeps one pending bit per pin. A level pin is pending exactly while its input is high. An edge pin becomes pending on a rising input and stays pending until it is dispatched. A sweep walks the pins from pin 0 upward and emits one message for each pending pin that is not masked. A sweep is triggered by a newly pending pin or by any entry write, so unmasking an entry releases a held interrupt. Messages leave through a single-slot valid/ready port.

Top module: `irq_route_ctrl`

## Requirements
- R1: Only offsets 0x00 (selector, bits [7:0], readable) and 0x10 (data window) are decoded. Every other offset reads 0x00000000, and a write to it changes neither the selector nor any register.
- R2: Through the window, selector 0x00 holds an 8-bit ID in bits [31:24], and the other bits read zero. Selector 0x01 reads 0x00170011: version 0x11 in [7:0] and the highest entry number 23 in [23:16]. Selector 0x02 reads zero. Writes to 0x01 and 0x02 are ignored. Selectors 0x03 to 0x0F and those above the last entry read zero.
- R3: Entry n is reached at selector 0x10+2n for bits [31:0] and at 0x11+2n for bits [63:32]. A write to one half leaves the other half unchanged.
- R4: A message carries fields taken from its entry: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger mode [15] (1 = level) and destination [63:56]. Bit [16] is the mask.
- R5: A level pin is pending while its input is high and not pending once it is low. Each sweep that finds it high and unmasked sends one message for it. A sweep that runs after the pin has gone low sends nothing for it.
- R6: An edge pin becomes pending on a low-to-high input transition and stays pending after the input falls. Dispatch clears it, so one rising edge yields exactly one message.
- R7: A masked pin sends no message but keeps its pending state. A later write that clears the mask releases the message.
- R8: When several pins are pending in one sweep, messages leave in ascending pin order, one pin per dispatch.
- R9: At most one message is outstanding. While msg_valid is high and msg_ready is low, the message fields hold steady.
- R10: After reset, every entry reads 0x00000000_00010000 (masked), the ID and the selector read zero, and msg_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 24 | Interrupt pin levels |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_vector | output | 8 | Vector |
| msg_mode | output | 3 | Delivery mode |
| msg_dest | output | 8 | Destination |
| msg_dest_logical | output | 1 | Destination mode |
| msg_active_low | output | 1 | Polarity |
| msg_level | output | 1 | Trigger mode, 1 = level |

## Verification
If the pending state goes wrong, the message count shows it within one sweep of the next trigger, about 30 cycles. A stuck edge bit sends a message too many, a lost one sends a message too few, and a level pin that stays pending after going low sends on the following entry write. An entry word that is corrupted, or half-overwritten, shows up at once on a window read, and in the fields of the next message from that pin. A wrong sweep pointer or stall logic shows as an out-of-order pair of vectors, or as fields that change while msg_ready is held low.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    localparam logic [7:0] OFF_SEL      = 8'h00;
    localparam logic [7:0] OFF_WIN      = 8'h10;
    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ENT_BASE = 8'h10;
    localparam logic [7:0] VER_CODE     = 8'h11;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd_hi;
        logic        mask;
        logic        trig;
        logic        rsvd14;
        logic        pol;
        logic        rsvd12;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } rte_t;

    localparam rte_t RTE_RESET = rte_t'(64'h0000_0000_0001_0000);

    typedef struct packed {
        logic [7:0] dest;
        logic       dmode;
        logic       pol;
        logic       trig;
        logic [2:0] dlv;
        logic [7:0] vec;
    } msg_t;

    function automatic msg_t rte_to_msg(rte_t e);
        msg_t m;
        m.dest  = e.dest;
        m.dmode = e.dmode;
        m.pol   = e.pol;
        m.trig  = e.trig;
        m.dlv   = e.dlv;
        m.vec   = e.vec;
        return m;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [BUS_AW-1:0]          bus_addr,
    input  logic [BUS_DW-1:0]          bus_wdata,
    output logic [BUS_DW-1:0]          bus_rdata,
    output rte_t [NUM_PINS-1:0]        ent,
    output logic                       ent_wr
);
    localparam int ENT_END = int'(SEL_ENT_BASE) + 2 * NUM_PINS;
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VER_CODE};

    logic [7:0] sel_q;
    logic [7:0] id_q;
    logic [7:0] rel;
    logic [6:0] ent_n;
    logic       ent_hit;
    logic       win_wr;
    logic       sel_wr;
    logic [63:0] ent_word;

    assign rel     = sel_q - SEL_ENT_BASE;
    assign ent_n   = rel[7:1];
    assign ent_hit = (sel_q >= SEL_ENT_BASE) && (int'(sel_q) < ENT_END);
    assign win_wr  = bus_wr && (bus_addr == OFF_WIN);
    assign sel_wr  = bus_wr && (bus_addr == OFF_SEL);
    assign ent_wr  = win_wr && ent_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
            for (int i = 0; i < NUM_PINS; i++) ent[i] <= RTE_RESET;
        end else begin
            if (sel_wr) sel_q <= bus_wdata[7:0];
            if (win_wr && sel_q == SEL_ID) id_q <= bus_wdata[31:24];
            for (int i = 0; i < NUM_PINS; i++) begin
                if (ent_wr && int'(ent_n) == i) begin
                    if (sel_q[0]) ent[i][63:32] <= bus_wdata;
                    else          ent[i][31:0]  <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        ent_word = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (int'(ent_n) == i) ent_word = ent[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_SEL) begin
            bus_rdata = {24'h0, sel_q};
        end else if (bus_addr == OFF_WIN) begin
            if (sel_q == SEL_ID)       bus_rdata = {id_q, 24'h0};
            else if (sel_q == SEL_VER) bus_rdata = VER_WORD;
            else if (ent_hit)          bus_rdata = sel_q[0] ? ent_word[63:32] : ent_word[31:0];
        end
    end

    // R1
    sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != OFF_SEL) |=> $stable(sel_q));

    // R2
    id_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_WIN && sel_q == SEL_VER) |=> $stable(id_q));

endmodule

// File: rtl/irq_route_pending.sv
module irq_route_pending #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] pend,
    output logic                new_evt
);
    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] rise;

    assign rise    = pin_in & ~pin_q;
    assign new_evt = |rise;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_in;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)         pend[g] <= 1'b0;
            else if (lvl[g]) pend[g] <= pin_in[g];
            else             pend[g] <= rise[g] | (pend[g] & ~clr[g]);
        end

        // R6
        edge_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (!lvl[g] && pend[g] && !clr[g]) |=> pend[g]);
    end

    // R8
    clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr) && ((clr & ~pend) == '0));

endmodule

// File: rtl/irq_route_scan.sv
module irq_route_scan
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  rte_t [NUM_PINS-1:0] ent,
    input  logic [NUM_PINS-1:0] pend,
    input  logic                req,
    input  logic                msg_ready,
    output logic                msg_valid,
    output msg_t                msg,
    output logic [NUM_PINS-1:0] clr
);
    localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [PW-1:0] LAST = PW'(NUM_PINS - 1);

    logic          busy;
    logic          rerun;
    logic [PW-1:0] ptr;
    logic          can_load;
    logic          step;
    logic          take;
    logic          wrap;
    rte_t          cur;

    always_comb begin
        cur = ent[0];
        for (int i = 0; i < NUM_PINS; i++)
            if (int'(ptr) == i) cur = ent[i];
    end

    assign can_load = !msg_valid || msg_ready;
    assign step     = busy && can_load;
    assign take     = step && pend[ptr] && !cur.mask;
    assign wrap     = step && (ptr == LAST);

    always_comb begin
        clr = '0;
        if (take && !cur.trig) clr[ptr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            rerun     <= 1'b0;
            ptr       <= '0;
            msg_valid <= 1'b0;
            msg       <= '0;
        end else begin
            if (msg_valid && msg_ready) msg_valid <= 1'b0;
            if (take) begin
                msg       <= rte_to_msg(cur);
                msg_valid <= 1'b1;
            end
            if (step) begin
                if (wrap) begin
                    if (rerun || req) begin
                        ptr   <= '0;
                        rerun <= 1'b0;
                    end else begin
                        busy <= 1'b0;
                    end
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
            if (req && !wrap) begin
                if (busy) begin
                    rerun <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    ptr  <= '0;
                end
            end
        end
    end

    // R9
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !msg_valid);

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic [7:0]          msg_dest,
    output logic                msg_dest_logical,
    output logic                msg_active_low,
    output logic                msg_level
);
    rte_t [NUM_PINS-1:0] ent;
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] clr;
    logic                ent_wr;
    logic                new_evt;
    msg_t                msg;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_lvl
        assign lvl[g] = ent[g].trig;
    end

    irq_route_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent(ent), .ent_wr(ent_wr)
    );

    irq_route_pending #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk(clk), .rst(rst), .pin_in(pin_in), .lvl(lvl), .clr(clr),
        .pend(pend), .new_evt(new_evt)
    );

    irq_route_scan #(.NUM_PINS(NUM_PINS)) u_scan (
        .clk(clk), .rst(rst), .ent(ent), .pend(pend), .req(ent_wr | new_evt),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg(msg), .clr(clr)
    );

    assign msg_vector       = msg.vec;
    assign msg_mode         = msg.dlv;
    assign msg_dest         = msg.dest;
    assign msg_dest_logical = msg.dmode;
    assign msg_active_low   = msg.pol;
    assign msg_level        = msg.trig;

endmodule

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] pin_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic [7:0]  msg_dest;
    logic        msg_dest_logical;
    logic        msg_active_low;
    logic        msg_level;

    int total = 0;
    int bad = 0;

    logic [7:0]  cap_vec [0:63];
    logic [20:0] cap_all [0:63];
    int          cap_n = 0;

    always #2 clk = ~clk;

    irq_route_ctrl i_irq_route_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
        .msg_active_low(msg_active_low), .msg_level(msg_level)
    );

    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready && cap_n < 64) begin
            cap_vec[cap_n] = msg_vector;
            cap_all[cap_n] = {msg_dest, msg_mode, msg_dest_logical, msg_active_low, msg_level, msg_vector[4:0]};
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic win_write(input logic [7:0] s, input logic [31:0] d);
        bus_write(8'h00, {24'h0, s});
        bus_write(8'h10, d);
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        bus_write(8'h00, {24'h0, s});
        bus_read(8'h10, d);
    endtask

    task automatic pulse(input logic [23:0] m);
        @(negedge clk); pin_in = pin_in | m;
        @(negedge clk); @(negedge clk); pin_in = pin_in & ~m;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sel, write flag, write data, expected read
    localparam logic [72:0] TBL [0:9] = '{
        {8'h00, 1'b1, 32'hA512_3456, 32'hA500_0000},   // R2 ID field
        {8'h01, 1'b1, 32'hFFFF_FFFF, 32'h0017_0011},   // R2 version ignores write
        {8'h02, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},   // R2 reads zero
        {8'h10, 1'b1, 32'h0001_0031, 32'h0001_0031},   // R3 entry 0 low
        {8'h11, 1'b1, 32'h7E00_0000, 32'h7E00_0000},   // R3 entry 0 high
        {8'h10, 1'b0, 32'h0000_0000, 32'h0001_0031},   // R3 low kept
        {8'h3F, 1'b1, 32'h1234_5678, 32'h1234_5678},   // R3 entry 23 high
        {8'h3E, 1'b0, 32'h0000_0000, 32'h0001_0000},   // R3 entry 23 low kept
        {8'h40, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000},   // R2 beyond last entry
        {8'h05, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000}    // R2 unused selector
    };

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 msg_valid", {31'h0, msg_valid}, 32'h0);
        bus_read(8'h00, rd); chk("R10 selector", rd, 32'h0);
        bus_read(8'h10, rd); chk("R10 id", rd, 32'h0);
        win_read(8'h1A, rd); chk("R10 entry5 low", rd, 32'h0001_0000);
        win_read(8'h1B, rd); chk("R10 entry5 high", rd, 32'h0);

        for (int k = 0; k < 10; k++) begin
            if (TBL[k][64]) win_write(TBL[k][72:65], TBL[k][63:32]);
            win_read(TBL[k][72:65], rd);
            chk($sformatf("R2/R3 table row %0d", k), rd, TBL[k][31:0]);
        end

        // R1 undecoded offsets
        bus_write(8'h00, 32'h0000_0011);
        bus_write(8'h20, 32'h0000_0055);
        bus_read(8'h00, rd); chk("R1 selector unchanged", rd, 32'h11);
        bus_read(8'h20, rd); chk("R1 offset 0x20 zero", rd, 32'h0);
        bus_read(8'h04, rd); chk("R1 offset 0x04 zero", rd, 32'h0);
        bus_read(8'h10, rd); chk("R1 entry0 high intact", rd, 32'h7E00_0000);

        // R4 R6 edge pin with all fields
        win_write(8'h17, 32'h9C00_0000);
        win_write(8'h16, 32'h0000_2942);
        idle(40);
        base = cap_n;
        pulse(24'h000008);
        idle(60);
        chk("R6 one message per edge", cap_n - base, 1);
        chk("R4 fields", {11'h0, cap_all[base]}, {11'h0, 8'h9C, 3'd1, 1'b1, 1'b1, 1'b0, 5'h02});
        chk("R4 vector", {24'h0, cap_vec[base]}, 32'h42);
        win_write(8'h16, 32'h0000_2942);
        idle(60);
        chk("R6 cleared on dispatch", cap_n - base, 1);

        // R5 level pin
        win_write(8'h18, 32'h0000_8055);
        idle(40);
        base = cap_n;
        @(negedge clk); pin_in[4] = 1'b1;
        idle(60);
        chk("R5 level message", cap_n - base, 1);
        chk("R5 level vector", {24'h0, cap_vec[base]}, 32'h55);
        chk("R5 trigger bit", {31'h0, cap_all[base][5]}, 32'h1);
        win_write(8'h18, 32'h0000_8055);
        idle(60);
        chk("R5 still pending while high", cap_n - base, 2);
        @(negedge clk); pin_in[4] = 1'b0;
        idle(5);
        win_write(8'h18, 32'h0000_8055);
        idle(60);
        chk("R5 not pending when low", cap_n - base, 2);

        // R7 masked pin held then released
        win_write(8'h1C, 32'h0001_0066);
        idle(40);
        base = cap_n;
        pulse(24'h000040);
        idle(60);
        chk("R7 masked no message", cap_n - base, 0);
        win_write(8'h1C, 32'h0000_0066);
        idle(60);
        chk("R7 unmask releases", cap_n - base, 1);
        chk("R7 released vector", {24'h0, cap_vec[base]}, 32'h66);

        // R8 ascending order
        win_write(8'h24, 32'h0000_00A0);
        win_write(8'h28, 32'h0000_00C0);
        idle(40);
        base = cap_n;
        pulse(24'h001400);
        idle(60);
        chk("R8 two messages", cap_n - base, 2);
        chk("R8 first lower pin", {24'h0, cap_vec[base]}, 32'hA0);
        chk("R8 second higher pin", {24'h0, cap_vec[base + 1]}, 32'hC0);

        // R9 stall holds message
        win_write(8'h20, 32'h0000_0088);
        idle(40);
        base = cap_n;
        @(negedge clk); msg_ready = 1'b0;
        pulse(24'h000100);
        idle(40);
        chk("R9 valid while stalled", {31'h0, msg_valid}, 32'h1);
        chk("R9 vector while stalled", {24'h0, msg_vector}, 32'h88);
        idle(10);
        chk("R9 vector held", {24'h0, msg_vector}, 32'h88);
        chk("R9 nothing accepted", cap_n - base, 0);
        @(negedge clk); msg_ready = 1'b1;
        idle(20);
        chk("R9 one accepted", cap_n - base, 1);
        chk("R9 valid drops", {31'h0, msg_valid}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule